// File: doc/BRIEF.md
# Edge-Triggered Set/Clear Flip-Flop

This block holds one bit that is controlled by two independent inputs, one that sets it and one that clears it. It reacts only to a rising transition on either input. A level that stays high, on one input or on both, never changes the bit and never stops the other input from acting. Each input has its own edge detector. The detector gives an active-low pulse, one system-clock cycle wide, after it sees a rising transition, and that pulse commits the new value.

Both inputs are asynchronous to the system clock. By default each one passes through a two-flop synchronizer before its edge detector. A rising transition on an input changes the stored bit at the third rising clock edge after the transition. If a set transition and a clear transition are detected in the same cycle, the bit inverts. The block drives a true output and a complement output, and it brings out both detector pulses so they can be observed.

Top module: `edge_sr_ff`

## Requirements
- R1: A rising transition on `setIn` that is applied between clock edges makes `q` equal 1 after the third following rising clock edge, provided no clear transition is detected in the same cycle.
- R2: A rising transition on `clrIn` that is applied between clock edges makes `q` equal 0 after the third following rising clock edge, provided no set transition is detected in the same cycle.
- R3: Static levels never change `q`. This includes one input held high, both inputs held high, and either input falling.
- R4: A rising transition on one input takes effect while the other input is held high.
- R5: When set and clear transitions are detected in the same cycle, `q` inverts.
- R6: `setPulseN` and `clrPulseN` rest at 1. Each one is 0 for exactly one cycle, in the cycle after the second clock edge that follows its input's rise, which is the cycle just before `q` updates.
- R7: While `rst_n` is 0 at a clock edge, `q` becomes 0. An input that is already high when reset is released is treated as a level and not as an edge.
- R8: `qN` is always the complement of `q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| setIn | input | 1 | Set request, acts on its rising transition |
| clrIn | input | 1 | Clear request, acts on its rising transition |
| q | output | 1 | Stored bit |
| qN | output | 1 | Complement of the stored bit |
| setPulseN | output | 1 | Set edge pulse, active low |
| clrPulseN | output | 1 | Clear edge pulse, active low |

## Verification
The bench holds `setIn` high across reset release and expects `q` to stay 0. A design that does not preload its edge history would falsely set `q` here. The bench also keeps both inputs high for many cycles, which catches a level-sensitive design that drifts or blocks. It raises one input while the other is held high, which exposes a design where one level masks the other input. It raises both inputs on the same edge, where a design with a fixed priority would fail to invert `q`. Finally, a long random stretch is compared every cycle against a queue-based model, so a wrong latency or a pulse that lasts the wrong number of cycles would show up as a mismatch.

// File: rtl/edge_sr_pkg.sv
package edge_sr_pkg;
  typedef struct packed {
    logic setHit;
    logic clrHit;
  } srStrobe_t;
  localparam int NUM_CHAN = 2;
endpackage

// File: rtl/sr_edge_ctrl.sv
module sr_edge_ctrl
  import edge_sr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      setIn,
  input  logic      clrIn,
  output srStrobe_t strobe,
  output logic      setPulseN,
  output logic      clrPulseN
);
  logic [NUM_CHAN-1:0] rawIn;
  logic [NUM_CHAN-1:0] pulseN;

  assign rawIn = {clrIn, setIn};

  for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : gChan
    logic synced;
    logic hist;

    if (SYNC_STAGES > 0) begin : gSync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          chain <= {SYNC_STAGES{rawIn[ch]}};
        end else begin
          chain[0] <= rawIn[ch];
          for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
        end
      end
      assign synced = chain[SYNC_STAGES-1];
    end else begin : gBypass
      assign synced = rawIn[ch];
    end

    // history preloaded with the input level so a held input is not an edge
    always_ff @(posedge clk) begin
      if (!rst_n) hist <= rawIn[ch];
      else        hist <= synced;
    end

    assign pulseN[ch] = ~(synced & ~hist);

    // pulse lasts a single cycle
    assert_pulse_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !pulseN[ch] |=> pulseN[ch]);
  end

  assign setPulseN     = pulseN[0];
  assign clrPulseN     = pulseN[1];
  assign strobe.setHit = ~pulseN[0];
  assign strobe.clrHit = ~pulseN[1];
endmodule

// File: rtl/sr_edge_state.sv
module sr_edge_state
  import edge_sr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  srStrobe_t strobe,
  output logic      q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else begin
      unique case ({strobe.setHit, strobe.clrHit})
        2'b10:   q <= 1'b1;
        2'b01:   q <= 1'b0;
        2'b11:   q <= ~q;
        default: q <= q;
      endcase
    end
  end

  assert_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.setHit && !strobe.clrHit) |=> q);
  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.clrHit && !strobe.setHit) |=> !q);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.setHit && !strobe.clrHit) |=> $stable(q));
  assert_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.setHit && strobe.clrHit) |=> (q != $past(q)));
  assert_reset_R7: assert property (@(posedge clk)
    !rst_n |=> !q);
endmodule

// File: rtl/edge_sr_ff.sv
module edge_sr_ff
  import edge_sr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic setIn,
  input  logic clrIn,
  output logic q,
  output logic qN,
  output logic setPulseN,
  output logic clrPulseN
);
  srStrobe_t strobe;

  sr_edge_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .setIn     (setIn),
    .clrIn     (clrIn),
    .strobe    (strobe),
    .setPulseN (setPulseN),
    .clrPulseN (clrPulseN)
  );

  sr_edge_state i_state (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .q      (q)
  );

  assign qN = ~q;

  assert_pulse_to_q_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!setPulseN && clrPulseN) |=> q);
endmodule

// File: tb/test_edge_sr_ff.sv
module test_edge_sr_ff;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic setIn = 1'b0;
  logic clrIn = 1'b0;
  logic q, qN, setPulseN, clrPulseN;

  int nChecks = 0;
  int nFails = 0;

  always #2.5 clk = ~clk;

  edge_sr_ff i_edge_sr_ff (
    .clk(clk), .rst_n(rst_n), .setIn(setIn), .clrIn(clrIn),
    .q(q), .qN(qN), .setPulseN(setPulseN), .clrPulseN(clrPulseN)
  );

  // reference model: queues of input samples, newest at index 0
  bit sHist[$];
  bit cHist[$];
  bit mQ = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      sHist.delete(); cHist.delete();
      repeat (4) begin sHist.push_front(setIn); cHist.push_front(clrIn); end
      mQ = 1'b0;
    end else begin
      bit sEv, cEv;
      sHist.push_front(setIn); cHist.push_front(clrIn);
      if (sHist.size() > 8) begin void'(sHist.pop_back()); void'(cHist.pop_back()); end
      sEv = sHist[2] && !sHist[3];
      cEv = cHist[2] && !cHist[3];
      if (sEv && cEv) mQ = !mQ;
      else if (sEv)   mQ = 1'b1;
      else if (cEv)   mQ = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && sHist.size() >= 4) begin
      check(q == mQ, "R1/model q", q, mQ);
      check(qN == !q, "R8 complement", qN, !q);
      check(setPulseN == !(sHist[1] && !sHist[2]), "R6 set pulse", setPulseN,
            !(sHist[1] && !sHist[2]));
      check(clrPulseN == !(cHist[1] && !cHist[2]), "R6 clear pulse", clrPulseN,
            !(cHist[1] && !cHist[2]));
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin : stimulus
    // R7: set held high across reset release
    setIn = 1'b1;
    step(3);
    check(q == 1'b0 && qN == 1'b1, "R7 reset state", q, 0);
    rst_n = 1'b1;
    step(6);
    check(q == 1'b0, "R7 held input is a level", q, 0);
    check(setPulseN == 1'b1, "R7 no pulse after release", setPulseN, 1);

    // R1 with pulse timing R6
    setIn = 1'b0; step(4);
    setIn = 1'b1; step(2);
    check(setPulseN == 1'b0, "R6 set pulse low", setPulseN, 0);
    check(q == 1'b0, "R1 not yet", q, 0);
    step(1);
    check(q == 1'b1, "R1 set after three edges", q, 1);
    check(setPulseN == 1'b1, "R6 pulse one cycle", setPulseN, 1);

    // R2 and R4: clear rises while set held high
    step(3);
    clrIn = 1'b1; step(3);
    check(q == 1'b0, "R2 clear with set held (R4)", q, 0);

    // R3: both held high
    step(12);
    check(q == 1'b0, "R3 both high no change", q, 0);
    // R3: falling edges do nothing
    setIn = 1'b0; step(6);
    check(q == 1'b0, "R3 falling set ignored", q, 0);

    // R4: set rises while clear held high
    setIn = 1'b1; step(3);
    check(q == 1'b1, "R4 set with clear held", q, 1);
    clrIn = 1'b0; step(6);
    check(q == 1'b1, "R3 falling clear ignored", q, 1);

    // R5: simultaneous edges invert
    setIn = 1'b0; step(4);
    setIn = 1'b1; clrIn = 1'b1; step(3);
    check(q == 1'b0, "R5 toggle 1->0", q, 0);
    setIn = 1'b0; clrIn = 1'b0; step(4);
    setIn = 1'b1; clrIn = 1'b1; step(3);
    check(q == 1'b1, "R5 toggle 0->1", q, 1);

    // mid-run reset with clear held high, R7
    rst_n = 1'b0; step(2);
    check(q == 1'b0, "R7 reset clears q", q, 0);
    setIn = 1'b0; rst_n = 1'b1; step(6);
    check(q == 1'b0, "R7 held clear is a level", q, 0);

    // random stretch compared against the model
    for (int i = 0; i < 400; i++) begin
      setIn = ($urandom_range(0, 3) == 0) ? ~setIn : setIn;
      clrIn = ($urandom_range(0, 3) == 0) ? ~clrIn : clrIn;
      step(1);
    end
    step(4);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule